// File: doc/BRIEF.md
# Synchronisable Blink Timer

This block produces the on/off phase used to blank a multiplexed LED display while blinking is switched on. It counts ticks of a slow time base and flips between a visible phase and a blanked phase of equal length. Two rates are offered: a fast one whose half period is `FAST_HALF_TICKS` ticks and a slow one whose half period is `SLOW_MULT` times longer. With a 1 kHz tick and the default values, these give a period of about 1 s and about 2 s.

Several drivers can blink in step. When the resync enable is set, every load/chip-select rising-edge pulse clears the phase counter and restarts blinking in the configured start phase. The start phase is either visible or blanked and is chosen by a feature bit. A rate change never cuts a phase short. It is applied at the next phase boundary.

The only output is a blank request to the scan engine. The scan engine turns all digits off while this request is high.

Top module: `blink_timer`

## Requirements
- R1: After reset, blank_o is 0.
- R2: While blink_en_i is 0, blank_o is 0 whatever the other inputs do. The counter is held cleared and the phase is held at the start phase.
- R3: In the cycle where blink_en_i first reads 1, the display is in the start phase: blank_o=0 if start_on_i=1 (visible) and blank_o=1 if start_on_i=0 (blanked). That first phase lasts a full half period.
- R4: With the rate latched at 0 (fast), each phase lasts exactly FAST_HALF_TICKS ticks.
- R5: With the rate latched at 1 (slow), each phase lasts exactly FAST_HALF_TICKS*SLOW_MULT ticks.
- R6: Within one rate, the visible and blanked phases are equal in length (50% duty).
- R7: When sync_en_i=1 and load_rise_i=1, the counter is cleared in that cycle. From the next cycle the phase equals start_on_i and a full half period begins. A tick in the same cycle is ignored.
- R8: When sync_en_i=0, load_rise_i has no effect on blank_o.
- R9: A change of slow_rate_i takes effect only at the next phase boundary, at a restart, or while disabled. The phase in progress keeps its length.
- R10: Cycles without tick_i leave the counter and the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick, one-cycle pulse |
| blink_en_i | input | 1 | Blink enable |
| slow_rate_i | input | 1 | Rate select: 0 fast, 1 slow |
| sync_en_i | input | 1 | Allow load edges to resynchronise |
| start_on_i | input | 1 | Start phase: 1 visible, 0 blanked |
| load_rise_i | input | 1 | Pulse on load/chip-select rising edge |
| blank_o | output | 1 | Blank request to scan engine |

## Verification
The bench builds the block with FAST_HALF_TICKS=3 and SLOW_MULT=2. Fast phases therefore last 3 ticks and slow phases 6 ticks. Hundreds of phase boundaries, rate switches in the middle of a phase, and resyncs landing on or next to a wrap all fit within a few thousand cycles. Ticks arrive both on every cycle and sparsely. This exercises the hold behaviour between ticks and the case where a load edge and a tick coincide.

// File: rtl/blink_pkg.sv
package blink_pkg;
  // Phase encoding: 1 = display visible, 0 = blanked
  typedef enum logic {PH_BLANK = 1'b0, PH_SHOW = 1'b1} phase_e;

  function automatic int unsigned half_ticks(input logic slow,
                                             input int unsigned fast_ticks,
                                             input int unsigned mult);
    return slow ? fast_ticks * mult : fast_ticks;
  endfunction
endpackage

// File: rtl/blink_rate_sel.sv
module blink_rate_sel #(
  parameter int unsigned FAST_HALF_TICKS = 500,
  parameter int unsigned SLOW_MULT       = 2,
  parameter int unsigned LIM_W           = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             wrap_i,
  input  logic             slow_rate_i,
  output logic [LIM_W-1:0] limit_o
);
  import blink_pkg::*;

  localparam logic [LIM_W-1:0] FAST_LIM = LIM_W'(half_ticks(1'b0, FAST_HALF_TICKS, SLOW_MULT));
  localparam logic [LIM_W-1:0] SLOW_LIM = LIM_W'(half_ticks(1'b1, FAST_HALF_TICKS, SLOW_MULT));

  logic rate_q;

  // rate only latched at a boundary or restart so a phase is never cut
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rate_q <= 1'b0;
    else if (restart_i || wrap_i) rate_q <= slow_rate_i;
  end

  assign limit_o = rate_q ? SLOW_LIM : FAST_LIM;

  // R9
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !wrap_i) |=> $stable(limit_o));
endmodule

// File: rtl/blink_phase_cnt.sv
module blink_phase_cnt #(
  parameter int unsigned LIM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             wrap_o
);
  logic [LIM_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == limit_i - LIM_W'(1));
  assign wrap_o = tick_i && !restart_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= at_end ? '0 : cnt_q + LIM_W'(1);
  end

  // R4 R5
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);
  // R10
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(cnt_q));
  // R7
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/blink_phase_reg.sv
module blink_phase_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic wrap_i,
  input  logic start_on_i,
  output logic show_o
);
  import blink_pkg::*;

  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= PH_SHOW;
    else if (restart_i) phase_q <= phase_e'(start_on_i);
    else if (wrap_i)    phase_q <= (phase_q == PH_SHOW) ? PH_BLANK : PH_SHOW;
  end

  assign show_o = (phase_q == PH_SHOW);

  // R7
  restart_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (show_o == $past(start_on_i)));
  // R6
  wrap_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !restart_i) |=> (show_o != $past(show_o)));
endmodule

// File: rtl/blink_timer.sv
module blink_timer #(
  parameter int unsigned FAST_HALF_TICKS = 500,
  parameter int unsigned SLOW_MULT       = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic blink_en_i,
  input  logic slow_rate_i,
  input  logic sync_en_i,
  input  logic start_on_i,
  input  logic load_rise_i,
  output logic blank_o
);
  localparam int unsigned SLOW_HALF = FAST_HALF_TICKS * SLOW_MULT;
  localparam int unsigned LIM_W     = $clog2(SLOW_HALF + 1);

  logic             restart;
  logic             wrap;
  logic             show;
  logic [LIM_W-1:0] limit;

  // disabled state keeps everything parked at the start phase
  assign restart = !blink_en_i || (sync_en_i && load_rise_i);

  blink_rate_sel #(
    .FAST_HALF_TICKS(FAST_HALF_TICKS),
    .SLOW_MULT      (SLOW_MULT),
    .LIM_W          (LIM_W)
  ) rate_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .wrap_i     (wrap),
    .slow_rate_i(slow_rate_i),
    .limit_o    (limit)
  );

  blink_phase_cnt #(.LIM_W(LIM_W)) cnt_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .restart_i(restart),
    .limit_i  (limit),
    .wrap_o   (wrap)
  );

  blink_phase_reg phase_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .wrap_i    (wrap),
    .start_on_i(start_on_i),
    .show_o    (show)
  );

  assign blank_o = blink_en_i && !show;

  // R3
  en_start_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blink_en_i) |-> (blank_o == !$past(start_on_i)));
  // R8
  nosync_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blink_en_i && !sync_en_i && !tick_i) |=> !blink_en_i || $stable(blank_o));
endmodule

// File: tb/blink_timer_tb.sv
module blink_timer_tb_top;
  localparam int unsigned FAST = 3;
  localparam int unsigned MULT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, en = 1'b0, slow = 1'b0, sync = 1'b0, start_on = 1'b0, load = 1'b0;
  logic blank;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  blink_timer #(.FAST_HALF_TICKS(FAST), .SLOW_MULT(MULT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .blink_en_i(en),
    .slow_rate_i(slow), .sync_en_i(sync), .start_on_i(start_on),
    .load_rise_i(load), .blank_o(blank));

  // reference model built from the requirements
  int unsigned m_cnt;
  logic m_show, m_slow;

  function automatic int unsigned phase_len(input logic s);
    return s ? FAST * MULT : FAST;
  endfunction

  function automatic logic exp_blank();
    return en && !m_show;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_show = 1'b1; m_slow = 1'b0;
    end else if (!en || (sync && load)) begin
      m_cnt = 0; m_show = start_on; m_slow = slow;
    end else if (tick) begin
      if (m_cnt == phase_len(m_slow) - 1) begin
        m_cnt = 0; m_show = !m_show; m_slow = slow;
      end else m_cnt = m_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check_now();
    checks++;
    if (blank !== exp_blank()) begin
      errors++;
      $display("FAIL %s: blank_o=%0b expected=%0b at cycle %0d", tag, blank, exp_blank(), cycles);
    end
  endtask

  // drive inputs away from the edge, then check the combinational view
  task automatic step(input logic t, input logic e, input logic r,
                      input logic sy, input logic so, input logic ld);
    @(negedge clk);
    tick = t; en = e; slow = r; sync = sy; start_on = so; load = ld;
    #1;
    check_now();
  endtask

  task automatic run_steady(input int n, input logic r, input logic so, input logic every);
    for (int i = 0; i < n; i++)
      step(every ? 1'b1 : ($urandom % 3 == 0), 1'b1, r, 1'b0, so, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    #1;
    // R1 reset state
    tag = "R1";
    check_now();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    // R2 disabled: random everything else
    tag = "R2";
    for (int i = 0; i < 60; i++)
      step($urandom % 2, 1'b0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);

    // R3 enable with each start phase; R4 fast phases
    tag = "R3";
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    if (blank !== 1'b0) begin
      errors++; $display("FAIL R3: blank_o=%0b expected=0 on visible start", blank);
    end
    checks++;
    tag = "R4";
    run_steady(30, 1'b0, 1'b1, 1'b1);
    tag = "R3";
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    if (blank !== 1'b1) begin
      errors++; $display("FAIL R3: blank_o=%0b expected=1 on blanked start", blank);
    end
    checks++;
    tag = "R6";
    run_steady(30, 1'b0, 1'b0, 1'b1);

    // R5 slow phases after a restart
    tag = "R5";
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    run_steady(50, 1'b1, 1'b1, 1'b1);

    // R10 sparse ticks
    tag = "R10";
    run_steady(80, 1'b0, 1'b1, 1'b0);
    run_steady(80, 1'b1, 1'b1, 1'b0);

    // R9 rate flips in mid-phase
    tag = "R9";
    for (int i = 0; i < 120; i++)
      step(1'b1, 1'b1, (i % 5) < 2, 1'b0, 1'b1, 1'b0);

    // R7 resync with load pulses, including coinciding ticks
    tag = "R7";
    for (int i = 0; i < 150; i++)
      step($urandom % 2, 1'b1, $urandom % 2, 1'b1, $urandom % 2, ($urandom % 4) == 0);

    // R8 load pulses without sync are ignored
    tag = "R8";
    for (int i = 0; i < 150; i++)
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, $urandom % 2);

    // mixed random; R4 R5 R6 R7 R9 together
    tag = "R4";
    for (int i = 0; i < 1500; i++)
      step($urandom % 2, ($urandom % 32) != 0, ($urandom % 8) == 0 ? ~slow : slow,
           ($urandom % 16) == 0 ? ~sync : sync, $urandom % 2, ($urandom % 12) == 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule